// File: doc/BRIEF.md
# Parallel Binary-Input Predistortion FIR

This block is a multi-lane FIR filter for a transmitter that pre-compensates fibre chromatic dispersion before the signal reaches the line. Each clock it accepts a word of `LANES` data bits, oldest bit in bit 0. For every bit it produces two output samples, one on the bit itself and one half a bit later, each quantised to a small signed code for a downstream multiplexer and DAC. Because each input is a single bit, every tap contributes either its coefficient or its negation, so there are no multipliers. The impulse response is symmetric, so mirrored taps share one stored coefficient. A pair of mirrored bits then contributes twice the coefficient, minus twice the coefficient, or nothing.

A bit history register carries the last `TAPS-1` accepted bits across word boundaries, so the first lanes of a word see their full tap window. Two coefficient sets, one per sample phase, arrive as static input vectors that a register bank outside the block or a set of constants can drive. The datapath has five register stages: window capture, split folded partial sums, final sum, rounding with saturation, and the output register.

Top module: `pdfir_top`

## Requirements
- R1: After reset, `out_valid` is 0, every output sample is 0 and the bit history holds all zeros, so the first word after reset sees earlier bits as value 0.
- R2: A bit of value 1 selects +c and a bit of value 0 selects -c for the coefficient c of its tap.
- R3: With TAPS = 55, the full-precision sum for one sample is the sum over taps k = 0..54 of the signed bit at age k times h[k], where h[k] = h[54-k] = coefficient index min(k, 54-k). Coefficient index i sits at bits [i*CW +: CW] of its coefficient vector, and index 27 is the centre tap.
- R4: Bit j of a word is stream position j after all bits of earlier accepted words. The tap window of every lane reaches back into previous words with no gap.
- R5: Output sample 2j is the even sample of input bit j, computed with `coef_even`. Sample 2j+1 is the odd sample of bit j, computed with `coef_odd`. Sample s occupies `out_samples[s*OUT_W +: OUT_W]` in two's complement.
- R6: The output is the sum plus 2^(SHIFT-1), shifted right arithmetically by SHIFT (default 6), so exact halves round toward plus infinity.
- R7: A rounded value above 2^(OUT_W-1)-1 gives 2^(OUT_W-1)-1, and one below -2^(OUT_W-1) gives -2^(OUT_W-1). The output never wraps.
- R8: A word taken with `in_valid` high on clock edge k appears on the outputs with `out_valid` high after edge k+4, five registers deep. `out_valid` is high in no other cycle.
- R9: Words offered with `in_valid` low are ignored and leave the bit history unchanged.
- R10: While `out_valid` is low, `out_samples` holds the last valid block (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word qualifier |
| in_bits | input | LANES | Data bits, bit 0 oldest |
| coef_even | input | HALF*CW | Folded coefficients, on-bit phase |
| coef_odd | input | HALF*CW | Folded coefficients, half-bit phase |
| out_valid | output | 1 | Output block qualifier |
| out_samples | output | 2*LANES*OUT_W | Quantised samples, two per input bit |

## Verification
A history register that shifts on an idle word, or one that keeps the wrong bits, corrupts the samples of the next valid word. The error shows four edges after that word is taken and persists for up to TAPS-1 bits of stream. A wrong pairing of mirrored taps or a swapped phase gives wrong codes in the first output block of any word with mixed bits. A pipeline valid that is out of step shows as an `out_valid` pulse in the wrong cycle, or as output samples that change while `out_valid` is low.

// File: rtl/pdfir_pkg.sv
package pdfir_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    function automatic int half_taps(input int taps);
        return (taps + 1) / 2;
    endfunction

endpackage

// File: rtl/pdfir_tap_sum.sv
module pdfir_tap_sum #(
    parameter int TAPS  = 55,
    parameter int CW    = 8,
    parameter int ACC_W = 15
) (
    input  logic                          clk,
    input  logic [TAPS-1:0]               win,
    input  logic [((TAPS+1)/2)*CW-1:0]    coefs,
    output logic signed [ACC_W-1:0]       part_a,
    output logic signed [ACC_W-1:0]       part_b
);
    localparam int HALF  = (TAPS + 1) / 2;
    localparam int NPAIR = HALF - 1;
    localparam int SPLIT = NPAIR / 2;

    logic signed [CW-1:0]    ck;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] sum_a;
    logic signed [ACC_W-1:0] sum_b;

    always_comb begin
        sum_a = '0;
        sum_b = '0;
        ck    = '0;
        ext   = '0;
        term  = '0;
        for (int k = 0; k < NPAIR; k++) begin
            ck  = coefs[k*CW +: CW];
            ext = {{(ACC_W-CW){ck[CW-1]}}, ck} <<< 1;
            if (win[k] && win[TAPS-1-k])
                term = ext;
            else if (!win[k] && !win[TAPS-1-k])
                term = -ext;
            else
                term = '0;
            if (k < SPLIT)
                sum_a = sum_a + term;
            else
                sum_b = sum_b + term;
        end
        ck    = coefs[NPAIR*CW +: CW];
        ext   = {{(ACC_W-CW){ck[CW-1]}}, ck};
        sum_b = win[NPAIR] ? (sum_b + ext) : (sum_b - ext);
    end

    always_ff @(posedge clk) begin
        part_a <= sum_a;
        part_b <= sum_b;
    end

endmodule

// File: rtl/pdfir_quant.sv
module pdfir_quant #(
    parameter int ACC_W = 15,
    parameter int OUT_W = 4,
    parameter int SHIFT = 6
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic        [OUT_W-1:0] code
);
    localparam int XW = ACC_W + 1;
    localparam logic signed [XW-1:0] HALF_LSB = XW'(2 ** (SHIFT - 1));
    localparam logic signed [XW-1:0] QMAX     = XW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [XW-1:0] QMIN     = ~QMAX;

    logic signed [XW-1:0] wide;
    logic signed [XW-1:0] rnd;

    always_comb begin
        wide = {acc[ACC_W-1], acc};
        rnd  = (wide + HALF_LSB) >>> SHIFT;
        if (rnd > QMAX)
            code = QMAX[OUT_W-1:0];
        else if (rnd < QMIN)
            code = QMIN[OUT_W-1:0];
        else
            code = rnd[OUT_W-1:0];
    end

endmodule

// File: rtl/pdfir_top.sv
module pdfir_top
    import pdfir_pkg::*;
#(
    parameter int LANES = 64,
    parameter int TAPS  = 55,
    parameter int CW    = 8,
    parameter int OUT_W = 4,
    parameter int SHIFT = 6,
    localparam int HALF  = (TAPS + 1) / 2,
    localparam int HIST  = TAPS - 1,
    localparam int NOUT  = 2 * LANES,
    localparam int ACC_W = CW + $clog2(TAPS) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES-1:0]        in_bits,
    input  logic [HALF*CW-1:0]      coef_even,
    input  logic [HALF*CW-1:0]      coef_odd,
    output logic                    out_valid,
    output logic [NOUT*OUT_W-1:0]   out_samples
);
    localparam int XW = HIST + LANES;

    logic [HIST-1:0]          hist_q;
    logic [XW-1:0]            ext_w;
    logic [XW-1:0]            win_s1;
    logic                     v_s1, v_s2, v_s3, v_s4;

    logic signed [ACC_W-1:0]  pa_s2  [NOUT];
    logic signed [ACC_W-1:0]  pb_s2  [NOUT];
    logic signed [ACC_W-1:0]  acc_s3 [NOUT];
    logic        [OUT_W-1:0]  q_c    [NOUT];
    logic        [OUT_W-1:0]  q_s4   [NOUT];
    logic [NOUT*OUT_W-1:0]    out_q;

    assign ext_w = {in_bits, hist_q};

    // stage 1: window capture and history advance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            win_s1 <= '0;
            v_s1   <= 1'b0;
        end else begin
            win_s1 <= ext_w;
            v_s1   <= in_valid;
            if (in_valid)
                hist_q <= ext_w[XW-1:LANES];
        end
    end

    // stage 2: folded partial sums, one instance per lane and phase
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        for (genvar p = 0; p < 2; p++) begin : g_phase
            localparam phase_e PH = phase_e'(p);
            pdfir_tap_sum #(
                .TAPS (TAPS),
                .CW   (CW),
                .ACC_W(ACC_W)
            ) u_sum (
                .clk   (clk),
                .win   (win_s1[j +: TAPS]),
                .coefs ((PH == PH_ODD) ? coef_odd : coef_even),
                .part_a(pa_s2[2*j+p]),
                .part_b(pb_s2[2*j+p])
            );
        end
    end

    // stage 3 and 4: final sum, then rounding with saturation
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        pdfir_quant #(
            .ACC_W(ACC_W),
            .OUT_W(OUT_W),
            .SHIFT(SHIFT)
        ) u_quant (
            .acc (acc_s3[i]),
            .code(q_c[i])
        );

        always_ff @(posedge clk) begin
            acc_s3[i] <= pa_s2[i] + pb_s2[i];
            q_s4[i]   <= q_c[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_s2 <= 1'b0;
            v_s3 <= 1'b0;
            v_s4 <= 1'b0;
        end else begin
            v_s2 <= v_s1;
            v_s3 <= v_s2;
            v_s4 <= v_s3;
        end
    end

    // stage 5: output register, loads only on a valid block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= v_s4;
            if (v_s4) begin
                for (int i = 0; i < NOUT; i++)
                    out_q[i*OUT_W +: OUT_W] <= q_s4[i];
            end
        end
    end

    assign out_samples = out_q;

endmodule

// File: rtl/pdfir_chk.sv
module pdfir_chk #(
    parameter int LANES = 64,
    parameter int OUT_W = 4,
    parameter int ACC_W = 15,
    parameter int SHIFT = 6,
    parameter int HIST  = 54
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         out_valid,
    input  logic [2*LANES*OUT_W-1:0]     out_samples,
    input  logic [HIST-1:0]              hist,
    input  logic signed [ACC_W-1:0]      acc0,
    input  logic [OUT_W-1:0]             q0
);
    localparam int HI = (2 ** (OUT_W - 1)) * (2 ** SHIFT) - 2 ** (SHIFT - 1);
    localparam int LO = -(2 ** (OUT_W - 1)) * (2 ** SHIFT) - 2 ** (SHIFT - 1);
    localparam logic [OUT_W-1:0] CMAX = OUT_W'(2 ** (OUT_W - 1) - 1);
    localparam logic [OUT_W-1:0] CMIN = ~CMAX;

    logic [4:0] vtrack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vtrack <= '0;
        else        vtrack <= {vtrack[3:0], in_valid};
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vtrack[4]);

    a_r9_idle_keeps_history: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist));

    a_r10_hold_samples: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_samples));

    a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0 >= HI) |=> (q0 == CMAX));

    a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0 < LO) |=> (q0 == CMIN));

endmodule

bind pdfir_top pdfir_chk #(
    .LANES(LANES),
    .OUT_W(OUT_W),
    .ACC_W(ACC_W),
    .SHIFT(SHIFT),
    .HIST (HIST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_samples(out_samples),
    .hist       (hist_q),
    .acc0       (acc_s3[0]),
    .q0         (q_s4[0])
);

// File: tb/test_pdfir_top.sv
module test_pdfir_top;
    localparam int L     = 4;
    localparam int TAPS  = 55;
    localparam int CW    = 8;
    localparam int OUT_W = 4;
    localparam int SHIFT = 6;
    localparam int HALF  = (TAPS + 1) / 2;
    localparam int NOUT  = 2 * L;
    localparam int OW    = NOUT * OUT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [L-1:0] in_bits = '0;
    logic [HALF*CW-1:0] coef_even = '0;
    logic [HALF*CW-1:0] coef_odd = '0;
    logic out_valid;
    logic [OW-1:0] out_samples;

    always #2.5 clk = ~clk;

    pdfir_top #(.LANES(L), .TAPS(TAPS), .CW(CW), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_pdfir_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .coef_even(coef_even), .coef_odd(coef_odd),
        .out_valid(out_valid), .out_samples(out_samples)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    string req = "R1";
    int ce [HALF];
    int co [HALF];
    bit stream [$];
    logic           ev [8];
    logic [OW-1:0]  es [8];
    logic [OW-1:0]  last_ok = '0;

    function automatic int quant(input int acc);
        int r;
        r = (acc + (1 << (SHIFT - 1))) >>> SHIFT;
        if (r > 7) r = 7;
        if (r < -8) r = -8;
        return r;
    endfunction

    task automatic load_coefs();
        for (int k = 0; k < HALF; k++) begin
            coef_even[k*CW +: CW] = CW'(ce[k]);
            coef_odd[k*CW +: CW]  = CW'(co[k]);
        end
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [L-1:0] bits);
        int slot, old;
        logic [OW-1:0] blk;
        blk = '0;
        if (v) begin
            for (int j = 0; j < L; j++) stream.push_back(bits[j]);
            for (int j = 0; j < L; j++) begin
                for (int p = 0; p < 2; p++) begin
                    int n, acc, idx, c;
                    n = stream.size() - L + j;
                    acc = 0;
                    for (int k = 0; k < TAPS; k++) begin
                        idx = (k <= TAPS - 1 - k) ? k : TAPS - 1 - k;
                        c = (p == 0) ? ce[idx] : co[idx];
                        acc += stream[n-k] ? c : -c;
                    end
                    blk[(2*j+p)*OUT_W +: OUT_W] = OUT_W'(quant(acc));
                end
            end
            while (stream.size() > 200) void'(stream.pop_front());
        end
        slot = cyc % 8;
        ev[slot] = v;
        es[slot] = blk;
        in_valid = v;
        in_bits  = bits;
        @(posedge clk);
        @(negedge clk);
        old = (cyc + 4) % 8;
        check(32'(out_valid), 32'(ev[old]), "R8");
        if (ev[old]) begin
            for (int s = 0; s < NOUT; s++)
                check(32'(out_samples[s*OUT_W +: OUT_W]), 32'(es[old][s*OUT_W +: OUT_W]), req);
            last_ok = es[old];
        end else begin
            check(32'(out_samples), 32'(last_ok), "R10");
        end
        cyc++;
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) step(1'b0, L'($urandom));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; es[i] = '0; end
        for (int i = 0; i < TAPS - 1; i++) stream.push_back(1'b0);
        // set A: small distinct coefficients, odd set differs from even
        for (int k = 0; k < HALF; k++) begin
            ce[k] = k - 13;
            co[k] = 9 - (k % 7) * 3;
        end
        load_coefs();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(32'(out_valid), 32'd0, "R1");
        check(32'(out_samples), 32'd0, "R1");
        rst_n = 1'b1;
        // R1, R4: first words see a zero history
        req = "R1";
        step(1'b1, 4'b0000);
        step(1'b1, 4'b1111);
        // R2, R3, R5: patterns under set A
        req = "R2";
        for (int i = 0; i < 8; i++) step(1'b1, 4'b1111);
        req = "R3";
        step(1'b1, 4'b0001);
        for (int i = 0; i < 14; i++) step(1'b1, 4'b0000);
        req = "R5";
        for (int i = 0; i < 10; i++) step(1'b1, 4'b0101);
        req = "R4";
        for (int i = 0; i < 30; i++) step(1'b1, L'($urandom));
        // R9: idle words with noise must not disturb the history
        req = "R9";
        for (int i = 0; i < 30; i++) begin
            step(1'b0, L'($urandom));
            step(1'b1, L'($urandom));
            step(1'b0, 4'b1111);
        end
        // R6: exact half-step values
        flush();
        for (int k = 0; k < HALF; k++) begin ce[k] = 0; co[k] = 0; end
        ce[HALF-1] = 32;
        co[0] = 16;
        co[HALF-1] = 64;
        load_coefs();
        req = "R6";
        for (int i = 0; i < 40; i++) step(1'b1, L'($urandom));
        // R7: saturation at both ends
        flush();
        for (int k = 0; k < HALF; k++) begin ce[k] = 127; co[k] = -128; end
        load_coefs();
        req = "R7";
        for (int i = 0; i < 15; i++) step(1'b1, 4'b1111);
        for (int i = 0; i < 15; i++) step(1'b1, 4'b0000);
        for (int i = 0; i < 20; i++) step(1'b1, L'($urandom));
        flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule